// File: doc/BRIEF.md
# DMA Channel Request Scheduler

This block decides which channel of a multi-channel DMA controller may move its next data element. Each cycle it works out, for every channel, whether that channel could run. It uses the channel's configuration word, its remaining element count and the peripheral request lines. The lowest-numbered channel that can run receives a one-hot grant, which goes to the transfer engine.

The grant stays on that channel until the engine reports that the element has completed. The scheduler then drops the grant for one cycle and scans again from channel 0. A channel can therefore keep the grant element after element only if no lower-numbered channel is waiting.

Each channel's flow-control field selects how requests gate it. The channel can run without any request, or it can wait for the request of its destination peripheral, of its source peripheral, or of both. The single and burst request lines are merged before this test. Each channel also has a status flag that shows when its flow field holds a value this block does not support.

Top module: `dma_req_sched`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `grant_o` and `flow_err_o` are all zero.
- R2: A channel can be granted only when its configuration bit 0 (enable) is 1 and bit 18 (halt) is 0.
- R3: A channel whose 12-bit remaining count is zero is never granted.
- R4: Flow value 0 (configuration bits 13:11) grants with no peripheral request present.
- R5: Flow 1 needs the request of the destination peripheral, whose ID is in configuration bits 10:6. Flow 2 needs the request of the source peripheral, whose ID is in bits 5:1. Flow 3 needs both requests.
- R6: A peripheral counts as requesting when its bit is set in either `req_single_i` or `req_burst_i`.
- R7: No new grant is issued in a cycle where `glb_en_i` is 0.
- R8: Among the eligible channels, the one with the lowest index wins. `grant_o` has at most one bit set.
- R9: A grant is held unchanged until the cycle in which `elem_done_i` is 1. It is zero in the next cycle, and a fresh scan can grant again in the cycle after that.
- R10: A flow value from 4 to 7 makes the channel ineligible. The channel's `flow_err_o` bit is then 1 in the cycle after the channel is seen enabled and not halted with that value.
- R11: A peripheral ID of NREQ or above never counts as requesting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| glb_en_i | input | 1 | Global enable for new grants |
| ch_cfg_i | input | NCH*32 | Per-channel configuration words; channel c is at bits 32c+31:32c |
| ch_cnt_i | input | NCH*12 | Per-channel remaining element count |
| req_single_i | input | NREQ | Single-request lines, one per peripheral |
| req_burst_i | input | NREQ | Burst-request lines, one per peripheral |
| elem_done_i | input | 1 | The engine has completed the granted element |
| grant_o | output | NCH | One-hot grant, registered |
| flow_err_o | output | NCH | Unsupported-flow flag per channel, registered |

## Verification
Both outputs come from registers. A grant or error flag that follows from the inputs presented before a rising edge is visible right after that edge. A release caused by `elem_done_i` therefore shows as zero one cycle after the done pulse, and the next grant appears one cycle later. The bench drives inputs at the falling edge. At that point it computes the expected next state from those inputs and from its own model of the current grant, then compares after the following rising edge, at the next falling edge. Every check therefore covers exactly one register stage.

// File: rtl/dma_sched_pkg.sv
package dma_sched_pkg;
  localparam int CFG_W    = 32;
  localparam int CNT_W    = 12;
  localparam int ID_W     = 5;
  localparam int FLOW_W   = 3;
  localparam int EN_BIT   = 0;
  localparam int SRC_LSB  = 1;
  localparam int DST_LSB  = 6;
  localparam int FLOW_LSB = 11;
  localparam int HALT_BIT = 18;

  typedef enum logic [FLOW_W-1:0] {
    FLOW_MEM   = 3'd0,
    FLOW_DST   = 3'd1,
    FLOW_SRC   = 3'd2,
    FLOW_BOTH  = 3'd3
  } flow_e;
endpackage

// File: rtl/dma_chan_elig.sv
module dma_chan_elig
  import dma_sched_pkg::*;
#(
  parameter int NREQ = 16
) (
  input  logic [CFG_W-1:0] cfg_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [NREQ-1:0]  req_i,
  output logic             elig_o,
  output logic             bad_flow_o
);
  logic [ID_W-1:0]   src_id;
  logic [ID_W-1:0]   dst_id;
  logic [FLOW_W-1:0] flow;
  logic              active;
  logic              src_hit;
  logic              dst_hit;

  assign src_id = cfg_i[SRC_LSB +: ID_W];
  assign dst_id = cfg_i[DST_LSB +: ID_W];
  assign flow   = cfg_i[FLOW_LSB +: FLOW_W];
  assign active = cfg_i[EN_BIT] && !cfg_i[HALT_BIT];

  always_comb begin
    src_hit = 1'b0;
    dst_hit = 1'b0;
    for (int i = 0; i < NREQ; i++) begin
      if (src_id == ID_W'(i)) src_hit = req_i[i];
      if (dst_id == ID_W'(i)) dst_hit = req_i[i];
    end
  end

  always_comb begin
    elig_o     = 1'b0;
    bad_flow_o = 1'b0;
    if (active) begin
      case (flow)
        FLOW_MEM:  elig_o = 1'b1;
        FLOW_DST:  elig_o = dst_hit;
        FLOW_SRC:  elig_o = src_hit;
        FLOW_BOTH: elig_o = src_hit && dst_hit;
        default:   bad_flow_o = 1'b1;
      endcase
      if (cnt_i == '0) elig_o = 1'b0;
    end
  end
endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
  parameter int N = 8
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] pick_o
);
  always_comb begin
    logic found;
    found  = 1'b0;
    pick_o = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && !found) begin
        pick_o[i] = 1'b1;
        found     = 1'b1;
      end
    end
  end

  always_comb begin
    if (!$isunknown(req_i) && req_i != '0) begin
      // R8
      pick_lowest_chk: assert ((((pick_o - N'(1)) & req_i) == '0) && ((pick_o & req_i) != '0));
    end
  end
endmodule

// File: rtl/dma_req_sched.sv
module dma_req_sched
  import dma_sched_pkg::*;
#(
  parameter int NCH  = 8,
  parameter int NREQ = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 glb_en_i,
  input  logic [NCH*CFG_W-1:0] ch_cfg_i,
  input  logic [NCH*CNT_W-1:0] ch_cnt_i,
  input  logic [NREQ-1:0]      req_single_i,
  input  logic [NREQ-1:0]      req_burst_i,
  input  logic                 elem_done_i,
  output logic [NCH-1:0]       grant_o,
  output logic [NCH-1:0]       flow_err_o
);
  logic [NREQ-1:0] req_any;
  logic [NCH-1:0]  elig_w;
  logic [NCH-1:0]  bad_w;
  logic [NCH-1:0]  pick_w;
  logic [NCH-1:0]  grant_q, grant_d;
  logic [NCH-1:0]  err_q;
  logic            busy;

  assign req_any = req_single_i | req_burst_i;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dma_chan_elig #(.NREQ(NREQ)) u_elig (
      .cfg_i      (ch_cfg_i[c*CFG_W +: CFG_W]),
      .cnt_i      (ch_cnt_i[c*CNT_W +: CNT_W]),
      .req_i      (req_any),
      .elig_o     (elig_w[c]),
      .bad_flow_o (bad_w[c])
    );
  end

  dma_prio_pick #(.N(NCH)) u_pick (
    .req_i  (elig_w),
    .pick_o (pick_w)
  );

  assign busy = |grant_q;

  always_comb begin
    grant_d = grant_q;
    if (busy) begin
      if (elem_done_i) grant_d = '0;
    end else if (glb_en_i) begin
      grant_d = pick_w;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= '0;
      err_q   <= '0;
    end else begin
      grant_q <= grant_d;
      err_q   <= bad_w;
    end
  end

  assign grant_o    = grant_q;
  assign flow_err_o = err_q;

  // R8
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(grant_q));
  // R9
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !elem_done_i) |=> (grant_q == $past(grant_q)));
  // R9
  grant_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && elem_done_i) |=> (grant_q == '0));
  // R7
  glb_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !glb_en_i) |=> (grant_q == '0));
  // R2
  grant_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> ((grant_q & ~$past(elig_w)) == '0));
  // R10
  bad_flow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_w != '0) |=> ((err_q & $past(bad_w)) == $past(bad_w)));
  // R10
  bad_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_w & elig_w) == '0);
endmodule

// File: tb/sim_dma_req_sched.sv
module sim_dma_req_sched;
  localparam int NCH  = 8;
  localparam int NREQ = 16;

  logic              clk;
  logic              rst_n;
  logic              glb_en_i;
  logic [NCH*32-1:0] ch_cfg_i;
  logic [NCH*12-1:0] ch_cnt_i;
  logic [NREQ-1:0]   req_single_i;
  logic [NREQ-1:0]   req_burst_i;
  logic              elem_done_i;
  logic [NCH-1:0]    grant_o;
  logic [NCH-1:0]    flow_err_o;

  logic [31:0] cfg_a [NCH];
  logic [11:0] cnt_a [NCH];
  logic [NCH-1:0] exp_g;
  logic [NCH-1:0] exp_e;
  int checks;
  int errors;

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      ch_cfg_i[c*32 +: 32] = cfg_a[c];
      ch_cnt_i[c*12 +: 12] = cnt_a[c];
    end
  end

  dma_req_sched #(.NCH(NCH), .NREQ(NREQ)) u0 (
    .clk(clk), .rst_n(rst_n), .glb_en_i(glb_en_i),
    .ch_cfg_i(ch_cfg_i), .ch_cnt_i(ch_cnt_i),
    .req_single_i(req_single_i), .req_burst_i(req_burst_i),
    .elem_done_i(elem_done_i), .grant_o(grant_o), .flow_err_o(flow_err_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  initial begin
    #4000000;
    errors = errors + 1;
    checks = checks + 1;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  function automatic logic has_req(logic [4:0] id);
    logic [NREQ-1:0] r;
    r = req_single_i | req_burst_i;
    if (int'(id) >= NREQ) return 1'b0;
    return r[id];
  endfunction

  function automatic logic m_elig(int c);
    logic [31:0] f;
    f = cfg_a[c];
    if (!f[0] || f[18] || cnt_a[c] == 12'd0) return 1'b0;
    case (f[13:11])
      3'd0: return 1'b1;
      3'd1: return has_req(f[10:6]);
      3'd2: return has_req(f[5:1]);
      3'd3: return has_req(f[5:1]) && has_req(f[10:6]);
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [NCH-1:0] m_err();
    logic [NCH-1:0] e;
    for (int c = 0; c < NCH; c++)
      e[c] = cfg_a[c][0] && !cfg_a[c][18] && (cfg_a[c][13:11] >= 3'd4);
    return e;
  endfunction

  function automatic logic [NCH-1:0] m_next();
    if (exp_g != '0) return elem_done_i ? '0 : exp_g;
    if (!glb_en_i) return '0;
    for (int c = 0; c < NCH; c++)
      if (m_elig(c)) return NCH'(1) << c;
    return '0;
  endfunction

  task automatic compare(string tag);
    checks = checks + 1;
    if (grant_o !== exp_g || flow_err_o !== exp_e) begin
      errors = errors + 1;
      $display("FAIL %s grant=%h exp=%h err=%h exp=%h", tag, grant_o, exp_g, flow_err_o, exp_e);
    end
  endtask

  task automatic tick(string tag);
    logic [NCH-1:0] ng;
    logic [NCH-1:0] ne;
    ng = m_next();
    ne = m_err();
    @(negedge clk);
    exp_g = ng;
    exp_e = ne;
    compare(tag);
  endtask

  task automatic clear_all();
    for (int c = 0; c < NCH; c++) begin cfg_a[c] = '0; cnt_a[c] = '0; end
    req_single_i = '0; req_burst_i = '0;
    elem_done_i = (exp_g != '0);
    tick("R9 release");
    elem_done_i = 1'b0;
    tick("R1 idle");
  endtask

  function automatic logic [31:0] mk(logic en, logic halt, logic [2:0] fl, logic [4:0] s, logic [4:0] d);
    logic [31:0] w;
    w = '0;
    w[0] = en; w[18] = halt; w[13:11] = fl; w[5:1] = s; w[10:6] = d;
    return w;
  endfunction

  initial begin
    checks = 0; errors = 0;
    void'($urandom(1234));
    exp_g = '0; exp_e = '0;
    rst_n = 1'b0; glb_en_i = 1'b0; elem_done_i = 1'b0;
    req_single_i = '0; req_burst_i = '0;
    for (int c = 0; c < NCH; c++) begin cfg_a[c] = mk(1, 0, 3'd5, 0, 0); cnt_a[c] = 12'd3; end
    repeat (3) @(negedge clk);
    compare("R1 reset");
    for (int c = 0; c < NCH; c++) cfg_a[c] = '0;
    rst_n = 1'b1;
    tick("R1 after reset");

    // R7: global enable off blocks an eligible channel
    cfg_a[3] = mk(1, 0, 3'd0, 0, 0); cnt_a[3] = 12'd5;
    tick("R7 disabled");
    glb_en_i = 1'b1;
    tick("R4 flow0 grant");
    tick("R9 hold");
    elem_done_i = 1'b1; tick("R9 release");
    elem_done_i = 1'b0; tick("R9 regrant");
    clear_all();

    // R2 halt bit
    cfg_a[1] = mk(1, 1, 3'd0, 0, 0); cnt_a[1] = 12'd1;
    tick("R2 halted"); tick("R2 halted");
    cfg_a[1][18] = 1'b0; tick("R2 unhalted");
    clear_all();

    // R3 zero count
    cfg_a[0] = mk(1, 0, 3'd0, 0, 0); cnt_a[0] = 12'd0;
    tick("R3 zero count"); tick("R3 zero count");
    clear_all();

    // R5 R6 flow1 destination request via burst line only
    cfg_a[4] = mk(1, 0, 3'd1, 5'd2, 5'd9); cnt_a[4] = 12'd7;
    req_single_i = 16'h0004; tick("R5 flow1 src only");
    req_burst_i = 16'h0200; tick("R6 burst dest");
    clear_all();

    // R5 flow3 needs both
    cfg_a[2] = mk(1, 0, 3'd3, 5'd4, 5'd11); cnt_a[2] = 12'd2;
    req_single_i = 16'h0010; tick("R5 flow3 one req");
    req_single_i = 16'h0800; tick("R5 flow3 one req");
    req_burst_i = 16'h0010; tick("R5 flow3 both");
    clear_all();

    // R8 lowest wins
    cfg_a[5] = mk(1, 0, 3'd0, 0, 0); cnt_a[5] = 12'd9;
    cfg_a[2] = mk(1, 0, 3'd0, 0, 0); cnt_a[2] = 12'd9;
    tick("R8 lowest");
    elem_done_i = 1'b1; tick("R9 release");
    elem_done_i = 1'b0; cnt_a[2] = 12'd0; tick("R8 next");
    clear_all();

    // R10 bad flow
    cfg_a[6] = mk(1, 0, 3'd6, 0, 0); cnt_a[6] = 12'd4;
    tick("R10 bad flow"); tick("R10 bad flow");
    clear_all();

    // R11 out of range id
    cfg_a[7] = mk(1, 0, 3'd2, 5'd20, 5'd0); cnt_a[7] = 12'd4;
    req_single_i = '1; req_burst_i = '1;
    tick("R11 id range"); tick("R11 id range");
    clear_all();

    // random phase
    for (int it = 0; it < 3000; it++) begin
      glb_en_i = ($urandom % 8) != 0;
      for (int c = 0; c < NCH; c++) begin
        if (($urandom % 4) == 0) begin
          logic [2:0] fl;
          fl = 3'($urandom % 5);
          if (fl == 3'd4) fl = 3'(4 + $urandom % 4);
          cfg_a[c] = mk(($urandom % 4) != 0, ($urandom % 8) == 0, fl,
                        5'($urandom % 20), 5'($urandom % 20));
          cnt_a[c] = (($urandom % 6) == 0) ? 12'd0 : 12'($urandom);
        end
      end
      req_single_i = NREQ'($urandom & $urandom);
      req_burst_i  = NREQ'($urandom & $urandom & $urandom);
      elem_done_i  = (exp_g != '0) && (($urandom % 3) == 0);
      tick("R8 R9 R5 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule